// File: doc/BRIEF.md
# SPI Master Controller with Slave-Select Fault Detection

This block is a byte-wide serial peripheral interface controller that drives the bus as master. A four-address write port holds the clock settings, the mode bits and the data byte. Writing the data byte while the controller is enabled as master starts an eight-bit exchange. The byte goes out on MOSI, most significant bit first. At the same time eight bits are collected from MISO. The serial clock is a power-of-two division of the system clock, and any of the four polarity/phase combinations can be selected.

The controller builds an internal select level from one of two sources: the external select pin, or a software bit held in the mode register. While it is master, it watches that level. If the level goes low, the controller treats it as a mode fault. It then drops out of master mode, disables itself, abandons any exchange in flight and raises a sticky fault flag. Software clears this flag through a dedicated clear address.

Top module: `spi_ctrl_master`

## Requirements
- R1: After reset, sck is 0 and busy, master_on, enabled, mode_fault, wr_collision and xfer_done are all 0.
- R2: Whenever no exchange is running, sck equals the polarity bit (address 0, bit 3).
- R3: With rate field r (address 0, bits 2:0), each sck half period lasts 2^r system cycles. The exchange produces 16 sck transitions, and xfer_done rises exactly 16*2^r cycles after the clock edge that accepted the data write.
- R4: Bits leave on mosi MSB first. With the phase bit (address 0, bit 4) at 0, each bit is stable across the leading sck edge and changes on the trailing edge. With the phase bit at 1, each bit changes on the leading edge and is stable across the trailing edge.
- R5: miso is captured on the leading edge when phase=0 and on the trailing edge when phase=1, MSB first. When the exchange ends, rx_byte holds the received byte, xfer_done is high for exactly one cycle, and sck is back at its idle level.
- R6: When the software-select bit (address 1, bit 2) is 1, the internal select equals the select-value bit (address 1, bit 3) and the pin is ignored. When the software-select bit is 0, the internal select follows ss_pin.
- R7: If the internal select is low while master_on is 1, then on the next edge master_on and enabled are cleared, mode_fault is set, busy drops and sck returns to idle.
- R8: A write to the data address (2) starts an exchange only if enabled (address 1, bit 0) and master_on (address 1, bit 1) are both 1. Otherwise busy stays 0.
- R9: A write to the data address while busy is ignored: the byte in flight is unchanged. The write sets wr_collision.
- R10: A mode write that sets the master bit before any write to address 0 since reset leaves master_on at 0.
- R11: A write to address 3 clears mode_fault when bit 0 is 1 and clears wr_collision when bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 clock settings, 1 mode, 2 data, 3 flag clear |
| wr_data | input | 8 | Register write data |
| ss_pin | input | 1 | External select pin, active low |
| miso | input | 1 | Serial data from the peer |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peer |
| xfer_done | output | 1 | One-cycle pulse at the end of an exchange |
| rx_byte | output | 8 | Last received byte |
| busy | output | 1 | Exchange in progress |
| master_on | output | 1 | Master bit state |
| enabled | output | 1 | Enable bit state |
| mode_fault | output | 1 | Sticky mode-fault flag |
| wr_collision | output | 1 | Sticky write-collision flag |

## Verification
Faults in the half-period counter or the edge counter show up at the pins within one sck half period. They cause a transition that comes early or late, or an xfer_done that misses its exact 16*2^r cycle slot. A wrong shift or sample edge corrupts the mosi stream the peer model captures and the rx_byte it reads back, and this is visible at the end of the same byte. A wrong select source or a missed fault check leaves master_on high one cycle after the select level drops, and sck keeps toggling when it should be idle.

// File: rtl/spi_ctrl_master.sv
module spi_ctrl_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       ss_pin,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       xfer_done,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       master_on,
  output logic       enabled,
  output logic       mode_fault,
  output logic       wr_collision
);
  logic [2:0] rate_q;
  logic       cpol_q, cpha_q, en_q, mstr_q, ssm_q, ssi_q, cfg_ok_q;
  logic       fault_q, wcol_q, busy_q, phase_q, done_q, mosi_q;
  logic [3:0] edge_q;
  logic [7:0] cnt_q, tx_q, rxsh_q, rx_q;

  logic       ss_int, fault_now, wr_ctrl, wr_mode, wr_dat, wr_clr;
  logic       tick, leading, trailing, last, start;
  logic [7:0] half;
  logic [2:0] bidx;

  assign ss_int    = ssm_q ? ssi_q : ss_pin;
  assign fault_now = mstr_q & ~ss_int;
  assign wr_ctrl   = wr_en && wr_addr == 2'd0;
  assign wr_mode   = wr_en && wr_addr == 2'd1;
  assign wr_dat    = wr_en && wr_addr == 2'd2;
  assign wr_clr    = wr_en && wr_addr == 2'd3;
  assign half      = 8'd1 << rate_q;
  assign tick      = busy_q && cnt_q == half - 8'd1;
  assign leading   = tick && !edge_q[0];
  assign trailing  = tick && edge_q[0];
  assign last      = trailing && edge_q == 4'd15;
  assign bidx      = edge_q[3:1];
  assign start     = wr_dat && en_q && mstr_q && !busy_q && !fault_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      en_q <= 1'b0; mstr_q <= 1'b0; ssm_q <= 1'b0; ssi_q <= 1'b0;
      cfg_ok_q <= 1'b0; fault_q <= 1'b0; wcol_q <= 1'b0;
      busy_q <= 1'b0; phase_q <= 1'b0; done_q <= 1'b0; mosi_q <= 1'b0;
      edge_q <= '0; cnt_q <= '0; tx_q <= '0; rxsh_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_ctrl && !busy_q) begin
        rate_q   <= wr_data[2:0];
        cpol_q   <= wr_data[3];
        cpha_q   <= wr_data[4];
        cfg_ok_q <= 1'b1;
      end
      if (wr_mode) begin
        en_q   <= wr_data[0];
        mstr_q <= wr_data[1] & cfg_ok_q;
        ssm_q  <= wr_data[2];
        ssi_q  <= wr_data[3];
      end
      if (wr_clr) begin
        if (wr_data[0]) fault_q <= 1'b0;
        if (wr_data[1]) wcol_q  <= 1'b0;
      end
      if (wr_dat && busy_q) wcol_q <= 1'b1;

      if (start) begin
        busy_q  <= 1'b1;
        tx_q    <= wr_data;
        mosi_q  <= wr_data[7];
        cnt_q   <= '0;
        edge_q  <= '0;
        phase_q <= 1'b0;
      end else if (busy_q) begin
        if (tick) begin
          cnt_q   <= '0;
          edge_q  <= edge_q + 4'd1;
          phase_q <= ~phase_q;
          if (leading) begin
            if (cpha_q) mosi_q <= tx_q[3'd7 - bidx];
            else        rxsh_q <= {rxsh_q[6:0], miso};
          end
          if (trailing) begin
            if (cpha_q) rxsh_q <= {rxsh_q[6:0], miso};
            else if (!last) mosi_q <= tx_q[3'd6 - bidx];
          end
          if (last) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            rx_q    <= cpha_q ? {rxsh_q[6:0], miso} : rxsh_q;
          end
        end else begin
          cnt_q <= cnt_q + 8'd1;
        end
      end

      if (wr_mode && !(wr_data[0] && wr_data[1] && cfg_ok_q)) begin
        busy_q  <= 1'b0;
        phase_q <= 1'b0;
      end
      if (fault_now) begin
        mstr_q  <= 1'b0;
        en_q    <= 1'b0;
        fault_q <= 1'b1;
        busy_q  <= 1'b0;
        phase_q <= 1'b0;
      end
    end
  end

  assign sck          = cpol_q ^ phase_q;
  assign mosi         = mosi_q;
  assign xfer_done    = done_q;
  assign rx_byte      = rx_q;
  assign busy         = busy_q;
  assign master_on    = mstr_q;
  assign enabled      = en_q;
  assign mode_fault   = fault_q;
  assign wr_collision = wcol_q;
endmodule

// File: rtl/spi_ctrl_master_chk.sv
module spi_ctrl_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       busy,
  input logic       sck,
  input logic       cpol,
  input logic       master_on,
  input logic       enabled,
  input logic       mode_fault,
  input logic       wr_collision,
  input logic       xfer_done,
  input logic       ss_int,
  input logic       cfg_ok
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck == cpol); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |=> !xfer_done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |-> (!busy && sck == cpol)); // R5
  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n) (master_on && !ss_int) |=> (!master_on && !enabled && mode_fault && !busy)); // R7
  AST_BUSY_MASTER: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (master_on && enabled)); // R8
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_addr == 2'd2 && busy) |=> wr_collision); // R9
  AST_MSTR_CFG: assert property (@(posedge clk) disable iff (!rst_n) $rose(master_on) |-> cfg_ok); // R10
endmodule

bind spi_ctrl_master spi_ctrl_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy),
  .sck(sck), .cpol(cpol_q), .master_on(master_on), .enabled(enabled),
  .mode_fault(mode_fault), .wr_collision(wr_collision), .xfer_done(xfer_done),
  .ss_int(ss_int), .cfg_ok(cfg_ok_q)
);

// File: tb/spi_ctrl_master_tb_top.sv
module spi_ctrl_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, ss_pin = 1'b1, miso = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sck, mosi, xfer_done, busy, master_on, enabled, mode_fault, wr_collision;
  logic [7:0] rx_byte;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  spi_ctrl_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ss_pin(ss_pin), .miso(miso), .sck(sck), .mosi(mosi), .xfer_done(xfer_done),
    .rx_byte(rx_byte), .busy(busy), .master_on(master_on), .enabled(enabled),
    .mode_fault(mode_fault), .wr_collision(wr_collision)
  );

  function automatic int half_of(input int r);
    return 1 << r;
  endfunction

  function automatic int done_at(input int r);
    return 16 * half_of(r);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_xfer(input int r, input bit cpol, input bit cpha,
                          input logic [7:0] tx, input logic [7:0] rxp, input bit collide);
    int n, edges, bitn, h;
    bit per_ok, prev, lead;
    logic [7:0] cap;
    h = half_of(r);
    ss_pin = 1'b1;
    wr(2'd0, {3'b000, cpha, cpol, r[2:0]});
    wr(2'd1, 8'b0000_1111);
    chk(sck == cpol, "R2 idle level", sck, cpol);
    miso = rxp[7];
    wr(2'd2, tx);
    n = 0; edges = 0; bitn = 0; per_ok = 1'b1; prev = sck; cap = '0;
    while (!xfer_done && n < done_at(r) + 4) begin
      @(negedge clk);
      n++;
      if (collide && n == 2) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = ~tx; end
      if (collide && n == 3) wr_en = 1'b0;
      if (sck != prev) begin
        edges++;
        if (n != edges * h) per_ok = 1'b0;
        lead = (sck != cpol);
        if (!cpha) begin
          if (lead) cap = {cap[6:0], mosi};
          else begin
            if (bitn < 7) miso = rxp[6 - bitn];
            bitn++;
          end
        end else begin
          if (lead) miso = rxp[7 - bitn];
          else begin
            cap = {cap[6:0], mosi};
            bitn++;
          end
        end
        prev = sck;
      end
    end
    chk(n == done_at(r), "R3 done cycle", n, done_at(r));
    chk(edges == 16 && per_ok, "R3 half period", edges, 16);
    chk(cap == tx, "R4 mosi byte", cap, tx);
    chk(rx_byte == rxp, "R5 rx byte", rx_byte, rxp);
    chk(sck == cpol && !busy, "R5 idle after", sck, cpol);
    @(negedge clk);
    chk(!xfer_done, "R5 single pulse", xfer_done, 0);
    if (collide) begin
      chk(wr_collision, "R9 collision flag", wr_collision, 1);
      wr(2'd3, 8'h02);
      chk(!wr_collision, "R11 clear collision", wr_collision, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(sck == 0 && !busy && !master_on && !enabled && !mode_fault && !wr_collision && !xfer_done,
        "R1 reset state", {sck, busy, master_on, enabled, mode_fault, wr_collision}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'd1, 8'b0000_1011);
    chk(!master_on, "R10 master before config", master_on, 0);
    chk(enabled, "R10 enable accepted", enabled, 1);
    wr(2'd2, 8'hA5);
    @(negedge clk);
    chk(!busy, "R8 no start without master", busy, 0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'b0000_1011);
    chk(master_on, "R10 master after config", master_on, 1);
    wr(2'd1, 8'b0000_1010);
    wr(2'd2, 8'h5A);
    @(negedge clk);
    chk(!busy, "R8 no start when disabled", busy, 0);

    for (int m = 0; m < 4; m++) run_xfer(0, m[1], m[0], 8'hC3 ^ 8'(m), 8'h69 + 8'(m), 1'b0);
    run_xfer(7, 1'b1, 1'b0, 8'h81, 8'h7E, 1'b0);
    run_xfer(2, 1'b0, 1'b1, 8'h3C, 8'hE1, 1'b1);

    ss_pin = 1'b0;
    wr(2'd1, 8'b0000_1111);
    repeat (3) @(negedge clk);
    chk(master_on && !mode_fault, "R6 pin ignored under software select", master_on, 1);
    wr(2'd1, 8'b0000_0111);
    @(negedge clk);
    chk(mode_fault && !master_on, "R6 software select low faults", mode_fault, 1);
    wr(2'd3, 8'h01);
    chk(!mode_fault, "R11 clear fault", mode_fault, 0);

    ss_pin = 1'b1;
    wr(2'd0, 8'b0000_1010);
    wr(2'd1, 8'b0000_0011);
    wr(2'd2, 8'h96);
    repeat (5) @(negedge clk);
    ss_pin = 1'b0;
    @(negedge clk);
    chk(!busy && !master_on && !enabled, "R7 drop out", {busy, master_on, enabled}, 0);
    chk(mode_fault && sck == 1'b1, "R7 fault and idle sck", {mode_fault, sck}, 3);
    ss_pin = 1'b1;
    wr(2'd3, 8'h01);
    chk(!mode_fault, "R11 clear after abort", mode_fault, 0);

    for (int i = 0; i < 16; i++)
      run_xfer($urandom % 5, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
               ($urandom % 4) == 0);
    summary();
  end
endmodule